// File: doc/BRIEF.md
# Range Register Update Sequencer

This block applies a stored target set of memory range registers (a default-type register, a list of variable base/mask pairs and eleven fixed-range registers) to a register bus. The writes must happen with caching held off. So the block first brackets the update with a lock request, a no-fill cache mode with a cache flush, global pages turned off with a TLB flush, and the range logic switched off through the default-type register. At the end it undoes these steps in the reverse order.

The block does not overwrite registers blindly. It reads each register back and compares it with the target through a compare mask chosen per field. It writes the register only when a compared bit differs. Three change bits record which classes of register were touched. A new default type or enable setting is not written on the spot: it is merged into the copy saved during preparation, so the final restore write applies it. The flush mechanics stay outside the block; only the request/acknowledge pairs reach it.

The block is started with a one-cycle `start_i`. `done_o` pulses once when the lock has been released.

Top module: `rangereg_update_seq`

## Requirements
- R1: After an accepted start, the preparation events occur in this exact order: lock request raised; read of the CTL0 register; write of CTL0 with bit 30 set and bit 29 cleared; cache flush request/acknowledge; read of CTL4; write of CTL4 with bit 7 cleared; TLB flush; read of the default-type register; write of the default-type register with bits 11:10 and 7:0 cleared.
- R2: A variable base register is rewritten with its target only if the read-back and the target differ in a bit selected by 32'hFFFF_F0FF in the low half, or by HI_CMP_MASK in the high half. Bits 11:8, and high bits outside HI_CMP_MASK, never cause a write.
- R3: A variable mask register is rewritten only if the read-back and the target differ under 32'hFFFF_F800 in the low half, or under HI_CMP_MASK in the high half.
- R4: When have_fixed_i is 1 at start, the eleven fixed registers at ADDR_FIX+0 through ADDR_FIX+10 are each read in ascending order: one 64K range, then two 16K ranges, then eight 4K ranges. Each is rewritten only when any of its 64 bits differs. When have_fixed_i is 0, none of them is accessed.
- R5: chg_mask_o bit 0 reports that at least one variable register was written, bit 1 that a fixed register was written, and bit 2 that the default-type setting changed.
- R6: If the saved default-type bits 7:0 differ from tgt_dt_type_i, or bits 11:10 differ from tgt_dt_en_i, the restore write carries the saved value with those two fields replaced. Otherwise it carries the saved value unchanged.
- R7: The finish events occur in this exact order: TLB flush; default-type restore write; read of CTL0; write of CTL0 with bit 30 cleared; write of CTL4 with its saved value; lock request dropped.
- R8: A bus request keeps valid, write, address and data stable until ready. All bus and flush requests occur while lock_req_o is high.
- R9: A write accepted with bus_err_i high sets err_o, and the sequence still runs to completion. err_o holds until the next accepted start clears it.
- R10: start_i pulses while a sequence is running have no effect: no second sequence follows.
- R11: After reset, done_o, err_o, chg_mask_o and all requests are 0. done_o is high for exactly one cycle per sequence, and chg_mask_o holds its final value until the next start.
- R12: Variable ranges are visited in ascending index i. For each range the base register at ADDR_VAR+2i is read (and written if needed) before the mask register at ADDR_VAR+2i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only when idle |
| have_fixed_i | input | 1 | Fixed-range registers are present |
| tgt_vbase_i | input | NUM_VAR*64 | Target base values, range i at bits 64i+63:64i |
| tgt_vmask_i | input | NUM_VAR*64 | Target mask values, range i at bits 64i+63:64i |
| tgt_fix_i | input | 11*64 | Target fixed-range values, register j at bits 64j+63:64j |
| tgt_dt_type_i | input | 8 | Target default memory type |
| tgt_dt_en_i | input | 2 | Target enable field of the default-type register |
| done_o | output | 1 | One-cycle completion pulse |
| chg_mask_o | output | 3 | Change mask {default, fixed, variable} |
| err_o | output | 1 | Sticky write-failure flag |
| bus_valid_o | output | 1 | Bus request valid |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | 64 | Write data |
| bus_ready_i | input | 1 | Bus accepts the request this cycle |
| bus_rdata_i | input | 64 | Read data, valid with ready |
| bus_err_i | input | 1 | Write failed, valid with ready |
| cflush_req_o | output | 1 | Cache flush request |
| cflush_ack_i | input | 1 | Cache flush done |
| tflush_req_o | output | 1 | TLB flush request |
| tflush_ack_i | input | 1 | TLB flush done |
| lock_req_o | output | 1 | Lock request, held for the whole sequence |
| lock_gnt_i | input | 1 | Lock granted |

## Verification
The bench targets register images that differ from their targets only in ignored bits: bits 11:8 of a base, bits 10:0 of a mask, and a high bit outside the compare window. A design with a wrong compare mask would issue extra writes there, and the scoreboard reports them as unexpected events. Other cases change just one fixed register, only the enable field of the default type, or turn the fixed set off. A design that drops the merge into the saved copy, or visits the fixed registers regardless, would restore the wrong default-type word or report the wrong change bits. One write is made to fail, to show that the error flag sticks while the remaining steps still complete. A start pulse in mid-sequence checks that no second lock request and no second sequence appear. Bus latencies of zero and two cycles exercise the hold-until-ready rule.

// File: rtl/rru_pkg.sv
`timescale 1ns/1ps
package rru_pkg;
  localparam int unsigned REG_W   = 64;
  localparam int unsigned NUM_FIX = 11;

  localparam int unsigned CHG_VAR = 0;
  localparam int unsigned CHG_FIX = 1;
  localparam int unsigned CHG_DEF = 2;

  localparam logic [31:0] VBASE_LO_CMP = 32'hFFFF_F0FF;
  localparam logic [31:0] VMASK_LO_CMP = 32'hFFFF_F800;

  localparam int unsigned CTL0_NOFILL = 30;
  localparam int unsigned CTL0_NOWT   = 29;
  localparam int unsigned CTL4_GPAGE  = 7;
  localparam logic [REG_W-1:0] DT_FIELDS = 64'h0000_0000_0000_0CFF;

  typedef enum logic [1:0] {CMP_VBASE, CMP_VMASK, CMP_FULL} cmp_kind_e;

  typedef enum logic [4:0] {
    S_IDLE, S_LOCK, S_CD_RD, S_CD_WR, S_CFLUSH, S_PG_RD, S_PG_WR, S_TFL_A,
    S_DT_RD, S_DT_WR, S_VAR_RD, S_VAR_WR, S_FIX_RD, S_FIX_WR, S_DT_EDIT,
    S_TFL_B, S_DT_RST, S_CD_RD2, S_CD_WR2, S_PG_RST, S_UNLOCK, S_DONE
  } seq_state_e;
endpackage

// File: rtl/rru_cmp.sv
`timescale 1ns/1ps
module rru_cmp
  import rru_pkg::*;
#(
  parameter logic [31:0] HI_CMP_MASK = 32'h0000_000F
) (
  input  cmp_kind_e        kind_i,
  input  logic [REG_W-1:0] cur_i,
  input  logic [REG_W-1:0] tgt_i,
  output logic             differ_o
);
  logic [REG_W-1:0] sel_mask;

  always_comb begin
    unique case (kind_i)
      CMP_VBASE: sel_mask = {HI_CMP_MASK, VBASE_LO_CMP};
      CMP_VMASK: sel_mask = {HI_CMP_MASK, VMASK_LO_CMP};
      default:   sel_mask = '1;
    endcase
  end

  assign differ_o = |((cur_i ^ tgt_i) & sel_mask);
endmodule

// File: rtl/rru_deftype_merge.sv
`timescale 1ns/1ps
module rru_deftype_merge
  import rru_pkg::*;
(
  input  logic [REG_W-1:0] saved_i,
  input  logic [7:0]       type_i,
  input  logic [1:0]       en_i,
  output logic [REG_W-1:0] merged_o,
  output logic             changed_o
);
  assign changed_o = (saved_i[7:0] != type_i) || (saved_i[11:10] != en_i);
  assign merged_o  = changed_o ? {saved_i[REG_W-1:12], en_i, saved_i[9:8], type_i}
                               : saved_i;
endmodule

// File: rtl/rru_bus_port.sv
`timescale 1ns/1ps
module rru_bus_port
  import rru_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic              bus_valid_o,
  output logic              bus_write_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [REG_W-1:0]  bus_wdata_o,
  input  logic              bus_ready_i,
  output logic              xfer_o
);
  logic              vld_q, vld_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  wdata_q;
  logic              load_en;

  assign load_en = issue_i && !vld_q;
  assign xfer_o  = vld_q && bus_ready_i;

  always_comb begin
    vld_d = vld_q;
    if (load_en)     vld_d = 1'b1;
    else if (xfer_o) vld_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load_en) begin
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign bus_valid_o = vld_q;
  assign bus_write_o = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;

  assert_req_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_addr_o)
      && $stable(bus_wdata_o) && $stable(bus_write_o)));

  assert_no_issue_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    issue_i |-> !bus_valid_o);
endmodule

// File: rtl/rangereg_update_seq.sv
`timescale 1ns/1ps
module rangereg_update_seq
  import rru_pkg::*;
#(
  parameter int unsigned       NUM_VAR     = 4,
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] ADDR_CTL0   = 'h00,
  parameter logic [ADDR_W-1:0] ADDR_CTL4   = 'h04,
  parameter logic [ADDR_W-1:0] ADDR_DEF    = 'h10,
  parameter logic [ADDR_W-1:0] ADDR_FIX    = 'h20,
  parameter logic [ADDR_W-1:0] ADDR_VAR    = 'h40,
  parameter logic [31:0]       HI_CMP_MASK = 32'h0000_000F
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     have_fixed_i,
  input  logic [NUM_VAR*REG_W-1:0] tgt_vbase_i,
  input  logic [NUM_VAR*REG_W-1:0] tgt_vmask_i,
  input  logic [NUM_FIX*REG_W-1:0] tgt_fix_i,
  input  logic [7:0]               tgt_dt_type_i,
  input  logic [1:0]               tgt_dt_en_i,
  output logic                     done_o,
  output logic [2:0]               chg_mask_o,
  output logic                     err_o,
  output logic                     bus_valid_o,
  output logic                     bus_write_o,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic [REG_W-1:0]         bus_wdata_o,
  input  logic                     bus_ready_i,
  input  logic [REG_W-1:0]         bus_rdata_i,
  input  logic                     bus_err_i,
  output logic                     cflush_req_o,
  input  logic                     cflush_ack_i,
  output logic                     tflush_req_o,
  input  logic                     tflush_ack_i,
  output logic                     lock_req_o,
  input  logic                     lock_gnt_i
);
  localparam int unsigned VAR_REGS = 2 * NUM_VAR;
  localparam int unsigned IDX_SPAN = (VAR_REGS > NUM_FIX) ? VAR_REGS : NUM_FIX;
  localparam int unsigned IDX_W    = $clog2(IDX_SPAN);
  localparam logic [IDX_W-1:0] VAR_LAST = IDX_W'(VAR_REGS - 1);
  localparam logic [IDX_W-1:0] FIX_LAST = IDX_W'(NUM_FIX - 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // target unpacking
  logic [REG_W-1:0] vbase_arr [NUM_VAR];
  logic [REG_W-1:0] vmask_arr [NUM_VAR];
  logic [REG_W-1:0] fix_arr   [NUM_FIX];

  for (genvar g = 0; g < NUM_VAR; g++) begin : g_var
    assign vbase_arr[g] = tgt_vbase_i[g*REG_W +: REG_W];
    assign vmask_arr[g] = tgt_vmask_i[g*REG_W +: REG_W];
  end
  for (genvar g = 0; g < NUM_FIX; g++) begin : g_fix
    assign fix_arr[g] = tgt_fix_i[g*REG_W +: REG_W];
  end

  // state
  seq_state_e       state_q, state_d;
  logic             iss_q, iss_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [REG_W-1:0] rd_q, rd_d;
  logic [REG_W-1:0] cr4_q, cr4_d;
  logic [REG_W-1:0] dt_q, dt_d;
  logic [2:0]       chg_q, chg_d;
  logic             err_q, err_d;
  logic             lock_q, lock_d;
  logic             hf_q, hf_d;

  // bus-port command
  logic              op_issue, op_we, xfer;
  logic [ADDR_W-1:0] op_addr;
  logic [REG_W-1:0]  op_wdata;

  // compare path
  logic             in_fix;
  cmp_kind_e        cmp_kind;
  logic [REG_W-1:0] var_tgt, fix_tgt, cmp_tgt;
  logic             differ;
  logic [REG_W-1:0] dt_merged;
  logic             dt_changed;

  always_comb begin
    var_tgt = '0;
    for (int k = 0; k < NUM_VAR; k++) begin
      if (idx_q[IDX_W-1:1] == (IDX_W-1)'(k))
        var_tgt = idx_q[0] ? vmask_arr[k] : vbase_arr[k];
    end
    fix_tgt = '0;
    for (int k = 0; k < NUM_FIX; k++) begin
      if (idx_q == IDX_W'(k)) fix_tgt = fix_arr[k];
    end
  end

  assign in_fix   = (state_q == S_FIX_RD) || (state_q == S_FIX_WR);
  assign cmp_kind = in_fix ? CMP_FULL : (idx_q[0] ? CMP_VMASK : CMP_VBASE);
  assign cmp_tgt  = in_fix ? fix_tgt : var_tgt;

  rru_cmp #(.HI_CMP_MASK(HI_CMP_MASK)) u_cmp (
    .kind_i  (cmp_kind),
    .cur_i   (bus_rdata_i),
    .tgt_i   (cmp_tgt),
    .differ_o(differ)
  );

  rru_deftype_merge u_merge (
    .saved_i  (dt_q),
    .type_i   (tgt_dt_type_i),
    .en_i     (tgt_dt_en_i),
    .merged_o (dt_merged),
    .changed_o(dt_changed)
  );

  rru_bus_port #(.ADDR_W(ADDR_W)) u_port (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .issue_i    (op_issue),
    .we_i       (op_we),
    .addr_i     (op_addr),
    .wdata_i    (op_wdata),
    .bus_valid_o(bus_valid_o),
    .bus_write_o(bus_write_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_ready_i(bus_ready_i),
    .xfer_o     (xfer)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    iss_d    = iss_q;
    idx_d    = idx_q;
    rd_d     = rd_q;
    cr4_d    = cr4_q;
    dt_d     = dt_q;
    chg_d    = chg_q;
    err_d    = err_q;
    lock_d   = lock_q;
    hf_d     = hf_q;
    op_issue = 1'b0;
    op_we    = 1'b0;
    op_addr  = '0;
    op_wdata = '0;

    unique case (state_q)
      S_IDLE: if (start_i) begin
        lock_d  = 1'b1;
        chg_d   = '0;
        err_d   = 1'b0;
        hf_d    = have_fixed_i;
        idx_d   = '0;
        state_d = S_LOCK;
      end
      S_LOCK: if (lock_gnt_i) state_d = S_CD_RD;
      S_CD_RD: begin
        op_issue = !iss_q;
        op_addr  = ADDR_CTL0;
        if (xfer) begin
          rd_d    = bus_rdata_i;
          state_d = S_CD_WR;
        end
      end
      S_CD_WR: begin
        op_issue = !iss_q;
        op_we    = 1'b1;
        op_addr  = ADDR_CTL0;
        op_wdata = rd_q;
        op_wdata[CTL0_NOFILL] = 1'b1;
        op_wdata[CTL0_NOWT]   = 1'b0;
        if (xfer) state_d = S_CFLUSH;
      end
      S_CFLUSH: if (cflush_ack_i) state_d = S_PG_RD;
      S_PG_RD: begin
        op_issue = !iss_q;
        op_addr  = ADDR_CTL4;
        if (xfer) begin
          cr4_d   = bus_rdata_i;
          state_d = S_PG_WR;
        end
      end
      S_PG_WR: begin
        op_issue = !iss_q;
        op_we    = 1'b1;
        op_addr  = ADDR_CTL4;
        op_wdata = cr4_q;
        op_wdata[CTL4_GPAGE] = 1'b0;
        if (xfer) state_d = S_TFL_A;
      end
      S_TFL_A: if (tflush_ack_i) state_d = S_DT_RD;
      S_DT_RD: begin
        op_issue = !iss_q;
        op_addr  = ADDR_DEF;
        if (xfer) begin
          dt_d    = bus_rdata_i;
          state_d = S_DT_WR;
        end
      end
      S_DT_WR: begin
        op_issue = !iss_q;
        op_we    = 1'b1;
        op_addr  = ADDR_DEF;
        op_wdata = dt_q & ~DT_FIELDS;
        if (xfer) state_d = S_VAR_RD;
      end
      S_VAR_RD, S_VAR_WR: begin
        op_issue = !iss_q;
        op_we    = (state_q == S_VAR_WR);
        op_addr  = ADDR_VAR + ADDR_W'(idx_q);
        op_wdata = cmp_tgt;
        if (xfer) begin
          if (state_q == S_VAR_WR) chg_d[CHG_VAR] = 1'b1;
          if (state_q == S_VAR_RD && differ) begin
            state_d = S_VAR_WR;
          end else if (idx_q == VAR_LAST) begin
            idx_d   = '0;
            state_d = hf_q ? S_FIX_RD : S_DT_EDIT;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = S_VAR_RD;
          end
        end
      end
      S_FIX_RD, S_FIX_WR: begin
        op_issue = !iss_q;
        op_we    = (state_q == S_FIX_WR);
        op_addr  = ADDR_FIX + ADDR_W'(idx_q);
        op_wdata = cmp_tgt;
        if (xfer) begin
          if (state_q == S_FIX_WR) chg_d[CHG_FIX] = 1'b1;
          if (state_q == S_FIX_RD && differ) begin
            state_d = S_FIX_WR;
          end else if (idx_q == FIX_LAST) begin
            idx_d   = '0;
            state_d = S_DT_EDIT;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = S_FIX_RD;
          end
        end
      end
      S_DT_EDIT: begin
        dt_d = dt_merged;
        if (dt_changed) chg_d[CHG_DEF] = 1'b1;
        state_d = S_TFL_B;
      end
      S_TFL_B: if (tflush_ack_i) state_d = S_DT_RST;
      S_DT_RST: begin
        op_issue = !iss_q;
        op_we    = 1'b1;
        op_addr  = ADDR_DEF;
        op_wdata = dt_q;
        if (xfer) state_d = S_CD_RD2;
      end
      S_CD_RD2: begin
        op_issue = !iss_q;
        op_addr  = ADDR_CTL0;
        if (xfer) begin
          rd_d    = bus_rdata_i;
          state_d = S_CD_WR2;
        end
      end
      S_CD_WR2: begin
        op_issue = !iss_q;
        op_we    = 1'b1;
        op_addr  = ADDR_CTL0;
        op_wdata = rd_q;
        op_wdata[CTL0_NOFILL] = 1'b0;
        if (xfer) state_d = S_PG_RST;
      end
      S_PG_RST: begin
        op_issue = !iss_q;
        op_we    = 1'b1;
        op_addr  = ADDR_CTL4;
        op_wdata = cr4_q;
        if (xfer) state_d = S_UNLOCK;
      end
      S_UNLOCK: begin
        lock_d  = 1'b0;
        state_d = S_DONE;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase

    if (op_issue) iss_d = 1'b1;
    if (xfer)     iss_d = 1'b0;
    if (xfer && bus_write_o && bus_err_i) err_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      iss_q   <= 1'b0;
      idx_q   <= '0;
      rd_q    <= '0;
      cr4_q   <= '0;
      dt_q    <= '0;
      chg_q   <= '0;
      err_q   <= 1'b0;
      lock_q  <= 1'b0;
      hf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      iss_q   <= iss_d;
      idx_q   <= idx_d;
      rd_q    <= rd_d;
      cr4_q   <= cr4_d;
      dt_q    <= dt_d;
      chg_q   <= chg_d;
      err_q   <= err_d;
      lock_q  <= lock_d;
      hf_q    <= hf_d;
    end
  end

  assign done_o       = (state_q == S_DONE);
  assign chg_mask_o   = chg_q;
  assign err_o        = err_q;
  assign lock_req_o   = lock_q;
  assign cflush_req_o = (state_q == S_CFLUSH);
  assign tflush_req_o = (state_q == S_TFL_A) || (state_q == S_TFL_B);

  assert_bus_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_valid_o || cflush_req_o || tflush_req_o) |-> lock_req_o);

  assert_cflush_after_cd_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(cflush_req_o) |-> $past(bus_valid_o && bus_ready_i && bus_write_o
      && bus_addr_o == ADDR_CTL0));

  assert_lock_from_start_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(lock_req_o) |-> $past(start_i));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> (!done_o && $stable(chg_mask_o)));

  assert_dt_restore_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == S_DT_RST && bus_valid_o) |->
      (bus_wdata_o[7:0] == tgt_dt_type_i && bus_wdata_o[11:10] == tgt_dt_en_i));
endmodule

// File: tb/rangereg_update_seq_tb.sv
`timescale 1ns/1ps
module rangereg_update_seq_tb;
  localparam int NV   = 4;
  localparam int NF   = 11;
  localparam int A_C0 = 'h00;
  localparam int A_C4 = 'h04;
  localparam int A_DT = 'h10;
  localparam int A_FX = 'h20;
  localparam int A_VR = 'h40;
  localparam logic [63:0] BASE_CM = 64'h0000_000F_FFFF_F0FF;
  localparam logic [63:0] MASK_CM = 64'h0000_000F_FFFF_F800;

  localparam int K_LOCK = 0, K_UNLOCK = 1, K_RD = 2, K_WR = 3, K_CFL = 4, K_TFL = 5;

  typedef struct {
    int          kind;
    int          addr;
    logic [63:0] data;
    string       tag;
  } ev_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_ni;
  logic             start_i, have_fixed_i;
  logic [NV*64-1:0] tgt_vbase_i, tgt_vmask_i;
  logic [NF*64-1:0] tgt_fix_i;
  logic [7:0]       tgt_dt_type_i;
  logic [1:0]       tgt_dt_en_i;
  logic             done_o, err_o;
  logic [2:0]       chg_mask_o;
  logic             bus_valid_o, bus_write_o;
  logic [7:0]       bus_addr_o;
  logic [63:0]      bus_wdata_o;
  logic             bus_ready_i, bus_err_i;
  logic [63:0]      bus_rdata_i;
  logic             cflush_req_o, cflush_ack_i, tflush_req_o, tflush_ack_i;
  logic             lock_req_o, lock_gnt_i;

  rangereg_update_seq #(.NUM_VAR(NV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .have_fixed_i(have_fixed_i),
    .tgt_vbase_i(tgt_vbase_i), .tgt_vmask_i(tgt_vmask_i), .tgt_fix_i(tgt_fix_i),
    .tgt_dt_type_i(tgt_dt_type_i), .tgt_dt_en_i(tgt_dt_en_i),
    .done_o(done_o), .chg_mask_o(chg_mask_o), .err_o(err_o),
    .bus_valid_o(bus_valid_o), .bus_write_o(bus_write_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i), .bus_rdata_i(bus_rdata_i),
    .bus_err_i(bus_err_i), .cflush_req_o(cflush_req_o), .cflush_ack_i(cflush_ack_i),
    .tflush_req_o(tflush_req_o), .tflush_ack_i(tflush_ack_i),
    .lock_req_o(lock_req_o), .lock_gnt_i(lock_gnt_i)
  );

  logic [63:0] mem [256];
  ev_t         exp_q[$];
  int          n_chk = 0, n_fail = 0;
  int          lat = 0, fail_addr = -1, wcnt = 0;
  logic [2:0]  exp_chg;
  logic        exp_err;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic push(input int kind, input int addr, input logic [63:0] data,
                      input string tag);
    ev_t e;
    e.kind = kind; e.addr = addr; e.data = data; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pop the next expected event and compare
  task automatic observe(input int kind, input int addr, input logic [63:0] data);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R8 unexpected event", 64'(kind * 1000 + addr), 64'hFFFF);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind && e.addr == addr && (kind != K_WR || e.data == data),
          {e.tag, " event kind/addr/data"},
          {8'(kind), 8'(addr), data[47:0]}, {8'(e.kind), 8'(e.addr), e.data[47:0]});
    end
  endtask

  // responder for bus, flushes and lock
  initial begin
    bus_ready_i = 0; bus_err_i = 0; bus_rdata_i = '0;
    cflush_ack_i = 0; tflush_ack_i = 0; lock_gnt_i = 0;
    forever begin
      @(negedge clk);
      if (bus_valid_o && !bus_ready_i) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0;
          bus_ready_i = 1;
          if (bus_write_o) begin
            observe(K_WR, int'(bus_addr_o), bus_wdata_o);
            if (int'(bus_addr_o) == fail_addr) bus_err_i = 1;
            else mem[bus_addr_o] = bus_wdata_o;
          end else begin
            bus_rdata_i = mem[bus_addr_o];
            observe(K_RD, int'(bus_addr_o), '0);
          end
        end
      end else begin
        bus_ready_i = 0; bus_err_i = 0;
      end
      if (cflush_req_o && !cflush_ack_i) begin observe(K_CFL, 0, '0); cflush_ack_i = 1; end
      else cflush_ack_i = 0;
      if (tflush_req_o && !tflush_ack_i) begin observe(K_TFL, 0, '0); tflush_ack_i = 1; end
      else tflush_ack_i = 0;
      if (lock_req_o && !lock_gnt_i) begin observe(K_LOCK, 0, '0); lock_gnt_i = 1; end
      else if (!lock_req_o && lock_gnt_i) begin observe(K_UNLOCK, 0, '0); lock_gnt_i = 0; end
    end
  end

  // driver: predict the whole event stream from the requirements
  task automatic build_expect();
    logic [63:0] m [256];
    logic [63:0] c0, c4, dt, w, t, cm;
    int a;
    for (int i = 0; i < 256; i++) m[i] = mem[i];
    exp_chg = '0; exp_err = 0;
    push(K_LOCK, 0, '0, "R1");
    push(K_RD, A_C0, '0, "R1");
    c0 = m[A_C0]; w = c0; w[30] = 1'b1; w[29] = 1'b0;
    push(K_WR, A_C0, w, "R1"); m[A_C0] = w;
    push(K_CFL, 0, '0, "R1");
    push(K_RD, A_C4, '0, "R1");
    c4 = m[A_C4]; w = c4; w[7] = 1'b0;
    push(K_WR, A_C4, w, "R1"); m[A_C4] = w;
    push(K_TFL, 0, '0, "R1");
    push(K_RD, A_DT, '0, "R1");
    dt = m[A_DT]; w = dt & ~64'hCFF;
    push(K_WR, A_DT, w, "R1"); m[A_DT] = w;
    for (int i = 0; i < NV; i++) begin
      for (int h = 0; h < 2; h++) begin
        a  = A_VR + 2 * i + h;
        t  = h ? tgt_vmask_i[i*64 +: 64] : tgt_vbase_i[i*64 +: 64];
        cm = h ? MASK_CM : BASE_CM;
        push(K_RD, a, '0, "R12");
        if (((m[a] ^ t) & cm) != 0) begin
          push(K_WR, a, t, h ? "R3" : "R2");
          exp_chg[0] = 1'b1;
          if (a == fail_addr) exp_err = 1'b1; else m[a] = t;
        end
      end
    end
    if (have_fixed_i) begin
      for (int j = 0; j < NF; j++) begin
        a = A_FX + j;
        t = tgt_fix_i[j*64 +: 64];
        push(K_RD, a, '0, "R4");
        if (m[a] != t) begin
          push(K_WR, a, t, "R4");
          exp_chg[1] = 1'b1;
          if (a == fail_addr) exp_err = 1'b1; else m[a] = t;
        end
      end
    end
    if (dt[7:0] != tgt_dt_type_i || dt[11:10] != tgt_dt_en_i) begin
      dt = {dt[63:12], tgt_dt_en_i, dt[9:8], tgt_dt_type_i};
      exp_chg[2] = 1'b1;
    end
    push(K_TFL, 0, '0, "R7");
    push(K_WR, A_DT, dt, "R6"); m[A_DT] = dt;
    push(K_RD, A_C0, '0, "R7");
    w = m[A_C0]; w[30] = 1'b0;
    push(K_WR, A_C0, w, "R7");
    push(K_WR, A_C4, c4, "R7");
    push(K_UNLOCK, 0, '0, "R7");
  endtask

  task automatic run_case(input string name, input bit busy_start);
    int cyc = 0;
    build_expect();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    while (!done_o && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (busy_start && cyc == 15) start_i = 1;
      if (busy_start && cyc == 16) start_i = 0;
    end
    chk(done_o == 1'b1, {"R11 done reached ", name}, 64'(done_o), 64'd1);
    chk(chg_mask_o == exp_chg, {"R5 change mask ", name}, 64'(chg_mask_o), 64'(exp_chg));
    chk(err_o == exp_err, {"R9 error flag ", name}, 64'(err_o), 64'(exp_err));
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, {"R7 all events seen ", name}, 64'(exp_q.size()), 64'd0);
    chk(done_o == 1'b0, {"R11 done one cycle ", name}, 64'(done_o), 64'd0);
    chk(chg_mask_o == exp_chg, {"R11 mask held ", name}, 64'(chg_mask_o), 64'(exp_chg));
    if (busy_start) begin
      repeat (20) @(negedge clk);
      chk(lock_req_o == 1'b0 && exp_q.size() == 0, "R10 no second sequence",
          64'(lock_req_o), 64'd0);
    end
  endtask

  task automatic load_equal();
    for (int i = 0; i < 256; i++) mem[i] = 64'(i) * 64'h0101_0000_0001_1000;
    mem[A_C0] = 64'h0000_0000_2000_0011;
    mem[A_C4] = 64'h0000_0000_0000_06F0;
    mem[A_DT] = 64'h0000_0000_0000_0C06;
    for (int i = 0; i < NV; i++) begin
      tgt_vbase_i[i*64 +: 64] = mem[A_VR + 2*i];
      tgt_vmask_i[i*64 +: 64] = mem[A_VR + 2*i + 1];
    end
    for (int j = 0; j < NF; j++) tgt_fix_i[j*64 +: 64] = mem[A_FX + j];
    tgt_dt_type_i = 8'h06;
    tgt_dt_en_i   = 2'b11;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 0; start_i = 0; have_fixed_i = 1;
    tgt_vbase_i = '0; tgt_vmask_i = '0; tgt_fix_i = '0;
    tgt_dt_type_i = '0; tgt_dt_en_i = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(done_o == 0 && err_o == 0, "R11 reset done/err", {62'd0, done_o, err_o}, 64'd0);
    chk(chg_mask_o == 0, "R11 reset mask", 64'(chg_mask_o), 64'd0);
    chk(!bus_valid_o && !lock_req_o && !cflush_req_o && !tflush_req_o,
        "R11 reset requests", {60'd0, bus_valid_o, lock_req_o, cflush_req_o, tflush_req_o}, 64'd0);

    // A: everything already matches, zero latency
    load_equal();
    lat = 0;
    run_case("all-equal", 0);

    // B: ignored-bit differences and real differences, latency 2 (R2 R3 R4 R6 R8)
    load_equal();
    lat = 2;
    tgt_vbase_i[0*64 +: 64] = mem[A_VR + 0] ^ 64'h0000_0000_0000_0A00; // bits 11:8 only
    tgt_vmask_i[0*64 +: 64] = mem[A_VR + 1] ^ 64'h0000_0000_0000_07FF; // bits 10:0 only
    tgt_vbase_i[1*64 +: 64] = mem[A_VR + 2] ^ 64'h0000_0000_0000_1000; // bit 12
    tgt_vmask_i[1*64 +: 64] = mem[A_VR + 3] ^ 64'h0000_0000_0000_0800; // bit 11
    tgt_vbase_i[2*64 +: 64] = mem[A_VR + 4] ^ 64'h0000_0100_0000_0000; // bit 40, outside window
    tgt_fix_i[5*64 +: 64]   = mem[A_FX + 5] ^ 64'h8000_0000_0000_0001;
    tgt_dt_type_i = 8'h00;
    run_case("mixed-diffs", 0);
    chk(mem[A_VR + 0] != tgt_vbase_i[63:0], "R2 ignored bits left unwritten",
        mem[A_VR + 0], ~tgt_vbase_i[63:0]);
    chk(mem[A_DT][11:0] == 12'hC00, "R6 restored type field", mem[A_DT], 64'hC00);

    // C: fixed set absent, only enable field changes (R4 R6)
    load_equal();
    lat = 1;
    have_fixed_i = 0;
    for (int j = 0; j < NF; j++) tgt_fix_i[j*64 +: 64] = ~mem[A_FX + j];
    tgt_dt_en_i = 2'b10;
    run_case("no-fixed", 0);
    chk(mem[A_FX] == 64'(A_FX) * 64'h0101_0000_0001_1000, "R4 fixed untouched",
        mem[A_FX], 64'(A_FX) * 64'h0101_0000_0001_1000);
    have_fixed_i = 1;

    // D: a failing write (R9)
    load_equal();
    lat = 0;
    tgt_vbase_i[1*64 +: 64] = mem[A_VR + 2] ^ 64'h0000_0000_00F0_0000;
    fail_addr = A_VR + 2;
    run_case("write-error", 0);

    // E: start while busy, error cleared on new start (R9 R10)
    fail_addr = -1;
    run_case("busy-start", 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule